// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block collects five interrupt request flags (external line 0, timer 0, external line 1, timer 1 and a serial flag formed from a receive flag OR a transmit flag), masks them with a writable enable register and splits them into a high and a low level with a writable level register. It keeps one in-service bit per level. Every clock it picks the winning request, if any. It then emits a one-cycle acknowledge pulse to the CPU together with the handler address for that source.

The flags are held inside the block. Hardware set pulses come in from the timers, the pins and the serial port. Software can overwrite all six flags at once, which raises a request or cancels a pending one. Vectoring clears the timer flags, clears an external flag only when that line is in edge mode, and never touches the serial flags. A return-from-interrupt pulse closes the most recent service. The acknowledge is a plain pulse with no back-pressure: the CPU is expected to take the vector in the cycle it appears.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the acknowledge is low, all six flags read 0, both levels are idle, and the enable and level registers are 0.
- R2: Enable register: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 7 global. A source whose bit is 0 is never acknowledged, even while its flag is set.
- R3: While the global enable bit 7 is 0, no acknowledge is issued, whatever the per-source bits hold.
- R4: The level register uses bits 4..0 in the same source order as the enable register, and 1 selects the high level. When requests of both levels are pending together, the high one is taken.
- R5: Within one level the fixed order is external 0, timer 0, external 1, timer 1, serial (first wins).
- R6: The vector is 0x0003 + 8 × source index (index 0..4 in the R5 order), giving 0x0003, 0x000B, 0x0013, 0x001B, 0x0023.
- R7: The acknowledge is high for exactly one cycle. It rises in the cycle after the winning flag first reads set, and the cycle after an acknowledge never carries another one.
- R8: A high request preempts a low service. A low request waits while a low service is open, and nothing is acknowledged while a high service is open.
- R9: A return pulse closes the high service if one is open, else the low service. A new acknowledge needs its level free again.
- R10: Flag bits read as 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 receive, 5 transmit. Vectoring clears a timer flag, and it clears an external flag only when that line's edge-mode input bit is 1. The receive and transmit flags are never cleared by vectoring.
- R11: A software flag write replaces all six flags. A hardware set pulse in the same cycle wins over both the write and a vectoring clear, so software can cancel a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | Enable register write data (bits 6:5 ignored) |
| lvl_wr | input | 1 | Write strobe for the level register |
| lvl_wdata | input | 8 | Level register write data (bits 7:5 ignored) |
| ext_edge | input | 2 | Per external line: 1 = edge mode (flag cleared on vectoring) |
| ext_set | input | 2 | Hardware set pulses for the external flags |
| tmr_set | input | 2 | Hardware set pulses for the timer overflow flags |
| rx_set | input | 1 | Hardware set pulse for the receive flag |
| tx_set | input | 1 | Hardware set pulse for the transmit flag |
| flag_wr | input | 1 | Software write strobe for all six flags |
| flag_wdata | input | 6 | Software flag value, R10 bit order |
| reti | input | 1 | Return-from-interrupt pulse |
| vec_ack | output | 1 | One-cycle acknowledge pulse |
| vec_addr | output | 16 | Handler address, valid while vec_ack is high |
| flag_q | output | 6 | Current flags, R10 bit order |

## Verification
A wrong in-service bit shows up as an acknowledge that is missing or comes when it should not. This is visible at most two cycles after the return pulse or the new request that should have changed the outcome. A flag left set or cleared wrongly after vectoring shows on flag_q in the cycle the acknowledge is high. An error in the level or order logic shows as a wrong vec_addr on the first acknowledge of a simultaneous pair. The bench compares every cycle against a behavioural model, so any such error is reported in the cycle it first reaches a port.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC   = 5;
  localparam int NFLAG  = 6;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int VEC_W  = 16;
  localparam int REG_W  = 8;
  localparam int GLB_BIT = 7;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
  localparam int VEC_STEP = 8;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_BASE + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] hw_set,
  input  logic          sw_wr,
  input  logic [NF-1:0] sw_data,
  input  logic [NF-1:0] vec_clr,
  output logic [NF-1:0] flag_q
);
  for (genvar g = 0; g < NF; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           flag_q[g] <= 1'b0;
      else if (hw_set[g])   flag_q[g] <= 1'b1;
      else if (sw_wr)       flag_q[g] <= sw_data[g];
      else if (vec_clr[g])  flag_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_svc.sv
module irqc_svc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant,
  input  logic       grant_hi,
  input  logic       reti,
  output logic [1:0] svc_q
);
  logic [1:0] svc_nxt;

  always_comb begin
    svc_nxt = svc_q;
    if (reti) begin
      if (svc_q[1]) svc_nxt[1] = 1'b0;
      else          svc_nxt[0] = 1'b0;
    end
    if (grant) svc_nxt[grant_hi] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) svc_q <= 2'b00;
    else        svc_q <= svc_nxt;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [REG_W-1:0] en_wdata,
  input  logic             lvl_wr,
  input  logic [REG_W-1:0] lvl_wdata,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       ext_set,
  input  logic [1:0]       tmr_set,
  input  logic             rx_set,
  input  logic             tx_set,
  input  logic             flag_wr,
  input  logic [NFLAG-1:0] flag_wdata,
  input  logic             reti,
  output logic             vec_ack,
  output logic [VEC_W-1:0] vec_addr,
  output logic [NFLAG-1:0] flag_q
);
  logic [NSRC-1:0]  en_src_q;
  logic             en_glb;
  logic [NSRC-1:0]  pr_q;
  logic [NFLAG-1:0] hw_set;
  logic [NFLAG-1:0] vec_clr;
  logic [NSRC-1:0]  src_req;
  logic [NSRC-1:0]  act;
  logic [1:0][NSRC-1:0]  lvl_req;
  logic [1:0]            lvl_hit;
  logic [1:0][IDX_W-1:0] lvl_idx;
  logic [1:0]       svc_q;
  logic             take_hi;
  logic             take_lo;
  logic             grant;
  logic [IDX_W-1:0] gidx;
  logic             ack_q;
  logic [VEC_W-1:0] vec_q;
  logic             unused_wbits;

  assign unused_wbits = ^{en_wdata[6:5], lvl_wdata[7:5]};

  // enable and level registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_src_q <= '0;
      en_glb   <= 1'b0;
      pr_q     <= '0;
    end else begin
      if (en_wr) begin
        en_src_q <= en_wdata[NSRC-1:0];
        en_glb   <= en_wdata[GLB_BIT];
      end
      if (lvl_wr) pr_q <= lvl_wdata[NSRC-1:0];
    end
  end

  assign hw_set = {tx_set, rx_set, tmr_set[1], ext_set[1], tmr_set[0], ext_set[0]};

  irqc_flags #(.NF(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_set  (hw_set),
    .sw_wr   (flag_wr),
    .sw_data (flag_wdata),
    .vec_clr (vec_clr),
    .flag_q  (flag_q)
  );

  // serial request is the OR of receive and transmit
  assign src_req = {flag_q[4] | flag_q[5], flag_q[3:0]};
  assign act     = src_req & en_src_q & {NSRC{en_glb}};
  assign lvl_req[1] = act & pr_q;
  assign lvl_req[0] = act & ~pr_q;

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    irqc_pick #(.N(NSRC)) u_pick (
      .req (lvl_req[g]),
      .hit (lvl_hit[g]),
      .idx (lvl_idx[g])
    );
  end

  // nesting rule: high needs no high open; low needs both idle
  assign take_hi = lvl_hit[1] && !svc_q[1];
  assign take_lo = !lvl_hit[1] && lvl_hit[0] && (svc_q == 2'b00);
  assign grant   = (take_hi || take_lo) && !ack_q;
  assign gidx    = take_hi ? lvl_idx[1] : lvl_idx[0];

  always_comb begin
    vec_clr = '0;
    if (grant) begin
      unique case (gidx)
        SRC_EXT0: vec_clr[0] = ext_edge[0];
        SRC_TMR0: vec_clr[1] = 1'b1;
        SRC_EXT1: vec_clr[2] = ext_edge[1];
        SRC_TMR1: vec_clr[3] = 1'b1;
        default:  vec_clr    = '0;
      endcase
    end
  end

  irqc_svc u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .grant_hi (take_hi),
    .reti     (reti),
    .svc_q    (svc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      vec_q <= '0;
    end else begin
      ack_q <= grant;
      if (grant) vec_q <= vec_of(gidx);
    end
  end

  assign vec_ack  = ack_q;
  assign vec_addr = vec_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             vec_ack,
  input logic [VEC_W-1:0] vec_addr,
  input logic [NFLAG-1:0] flag_q,
  input logic             en_glb,
  input logic [1:0]       svc,
  input logic [NFLAG-1:0] hw_set,
  input logic             flag_wr
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !vec_ack);

  a_r3_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_glb |=> !vec_ack);

  a_r6_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |-> (vec_addr[2:0] == 3'b011 && vec_addr[VEC_W-1:6] == '0 && vec_addr[5:3] <= 3'd4));

  a_r8_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    svc[1] |=> !vec_ack);

  a_r10_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && vec_addr == 16'h000B && !$past(hw_set[1]) && !$past(flag_wr)) |-> !flag_q[1]);

  a_r10_serial_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && vec_addr == 16'h0023 && !$past(flag_wr)) |->
      ((flag_q[5:4] & $past(flag_q[5:4])) == $past(flag_q[5:4])));
endmodule

bind prio_irq_ctrl irqc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vec_ack  (vec_ack),
  .vec_addr (vec_addr),
  .flag_q   (flag_q),
  .en_glb   (en_glb),
  .svc      (svc_q),
  .hw_set   (hw_set),
  .flag_wr  (flag_wr)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 0, lvl_wr = 0, flag_wr = 0, reti = 0, rx_set = 0, tx_set = 0;
  logic [7:0] en_wdata = 0, lvl_wdata = 0;
  logic [1:0] ext_edge = 2'b11, ext_set = 0, tmr_set = 0;
  logic [5:0] flag_wdata = 0;
  logic vec_ack;
  logic [15:0] vec_addr;
  logic [5:0] flag_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .ext_edge(ext_edge),
    .ext_set(ext_set), .tmr_set(tmr_set), .rx_set(rx_set), .tx_set(tx_set),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata), .reti(reti),
    .vec_ack(vec_ack), .vec_addr(vec_addr), .flag_q(flag_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [5:0] m_flag;
  logic [7:0] m_en;
  logic [4:0] m_pr;
  bit m_hi, m_lo, m_ack;
  int m_vec;

  always @(posedge clk) begin
    int pick;
    int plvl;
    logic [5:0] nf;
    logic [5:0] hs;
    if (!rst_n) begin
      m_flag = 0; m_en = 0; m_pr = 0; m_hi = 0; m_lo = 0; m_ack = 0; m_vec = 0;
    end else begin
      pick = -1;
      plvl = 0;
      for (int lv = 1; lv >= 0; lv--) begin
        if (pick < 0 && !m_hi && (lv == 1 || !m_lo)) begin
          for (int s = 0; s < 5; s++) begin
            if (pick < 0 && m_en[7] && m_en[s] && (int'(m_pr[s]) == lv) &&
                ((s == 4) ? (m_flag[4] | m_flag[5]) : m_flag[s])) begin
              pick = s;
              plvl = lv;
            end
          end
        end
      end
      if (m_ack) pick = -1;
      nf = m_flag;
      if (pick == 1) nf[1] = 0;
      if (pick == 3) nf[3] = 0;
      if (pick == 0 && ext_edge[0]) nf[0] = 0;
      if (pick == 2 && ext_edge[1]) nf[2] = 0;
      if (flag_wr) nf = flag_wdata;
      hs = {tx_set, rx_set, tmr_set[1], ext_set[1], tmr_set[0], ext_set[0]};
      m_flag = nf | hs;
      if (reti) begin
        if (m_hi) m_hi = 0;
        else m_lo = 0;
      end
      if (pick >= 0) begin
        if (plvl == 1) m_hi = 1;
        else m_lo = 1;
      end
      if (en_wr) m_en = en_wdata;
      if (lvl_wr) m_pr = lvl_wdata[4:0];
      m_ack = (pick >= 0);
      if (pick >= 0) m_vec = 3 + 8 * pick;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 ack timing vs model", vec_ack, m_ack);
      if (vec_ack) check("R6 vector vs model", vec_addr, m_vec);
      check("R10 flags vs model", flag_q, m_flag);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1; en_wdata = v; tick(1); en_wr = 0;
  endtask

  task automatic wr_lvl(input logic [7:0] v);
    lvl_wr = 1; lvl_wdata = v; tick(1); lvl_wr = 0;
  endtask

  task automatic wr_flags(input logic [5:0] v);
    flag_wr = 1; flag_wdata = v; tick(1); flag_wr = 0;
  endtask

  task automatic do_reti();
    reti = 1; tick(1); reti = 0;
  endtask

  task automatic hw(input logic [5:0] v);
    {tx_set, rx_set, tmr_set[1], ext_set[1], tmr_set[0], ext_set[0]} = v;
    tick(1);
    {tx_set, rx_set, tmr_set, ext_set} = '0;
  endtask

  task automatic expect_ack(input string tag, input int exp);
    int got;
    got = 'hFFFF;
    for (int i = 0; i < 12; i++) begin
      if (vec_ack) begin
        got = vec_addr;
        break;
      end
      tick(1);
    end
    check(tag, got, exp);
  endtask

  task automatic quiet(input string tag, input int n);
    int cnt;
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (vec_ack) cnt++;
    end
    check(tag, cnt, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 ack low in reset", vec_ack, 0);
    rst_n = 1;
    tick(1);
    check("R1 flags zero after reset", flag_q, 0);
    check("R1 ack low after reset", vec_ack, 0);

    // R3: global enable off
    wr_en(8'h1F);
    hw(6'b000001);
    quiet("R3 no ack with global off", 6);
    wr_en(8'h9F);
    expect_ack("R3 ack after global on", 'h0003);
    check("R10 edge ext0 flag cleared", flag_q[0], 0);
    tick(1);
    check("R7 no ack in next cycle", vec_ack, 0);
    do_reti();

    // R5: fixed order inside the low level
    wr_flags(6'b011110);
    expect_ack("R5 timer0 first", 'h000B);
    check("R10 timer0 flag cleared", flag_q[1], 0);
    do_reti();
    expect_ack("R5 ext1 second", 'h0013);
    do_reti();
    expect_ack("R5 timer1 third", 'h001B);
    check("R10 timer1 flag cleared", flag_q[3], 0);
    do_reti();
    expect_ack("R6 serial vector", 'h0023);
    check("R10 receive flag kept", flag_q[4], 1);
    wr_flags(6'b000000);
    do_reti();
    quiet("R11 software cancel", 6);

    // R4, R8, R9: two levels
    wr_lvl(8'h08);
    wr_flags(6'b001001);
    expect_ack("R4 high wins over low", 'h001B);
    quiet("R8 nothing preempts high", 6);
    do_reti();
    expect_ack("R9 low after high closes", 'h0003);
    hw(6'b000010);
    quiet("R8 low cannot preempt low", 6);
    hw(6'b001000);
    expect_ack("R8 high preempts low", 'h001B);
    do_reti();
    quiet("R9 low service still open", 6);
    do_reti();
    expect_ack("R9 pending low after both close", 'h000B);
    do_reti();

    // R11: hardware set wins over software write
    wr_lvl(8'h00);
    flag_wr = 1; flag_wdata = 6'b000000; ext_set[0] = 1;
    tick(1);
    flag_wr = 0; ext_set = 0;
    check("R11 set wins over write", flag_q[0], 1);
    expect_ack("R11 set raises request", 'h0003);
    do_reti();

    // R10: level-mode external keeps its flag
    ext_edge = 2'b00;
    hw(6'b000100);
    expect_ack("R10 level ext1 vector", 'h0013);
    check("R10 level ext1 flag kept", flag_q[2], 1);
    wr_flags(6'b000000);
    do_reti();
    ext_edge = 2'b11;

    // R2: per-source enable
    wr_en(8'h8F);
    hw(6'b010000);
    quiet("R2 disabled serial ignored", 6);
    check("R2 receive flag still set", flag_q[4], 1);
    wr_flags(6'b000000);
    wr_en(8'h9F);
    hw(6'b100000);
    expect_ack("R2 transmit via serial", 'h0023);
    check("R10 transmit flag kept", flag_q[5], 1);
    wr_flags(6'b000000);
    do_reti();
    quiet("R9 idle after final return", 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule